// File: doc/BRIEF.md
# Dual-Channel 6-Bit PWM Generator

This block turns two 6-bit codes into two pulse-width-modulated logic levels. A single free-running timebase counts 64 ticks per period. Each channel compares its own held code against that count and drives its output high while the count is below the code. A channel picks up a new code only at the period boundary, so a period that is already running is never cut short or stretched.

The tick rate is derived from the clock frequency and the target PWM frequency. The default is 64 ticks per 5 kHz period. An active-low shutdown input freezes the timebase and drops both output enables, which models released, high-impedance outputs. The held codes survive shutdown. When shutdown is released, the timebase restarts at the top of a period.

Top module: `dual_pwm_gen`

## Requirements
- R1: The timebase advances by one step every TICK_DIV clocks, where TICK_DIV = CLK_HZ / (PWM_HZ * 64) with a minimum of 1. One PWM period is 64 steps, which is 64 * TICK_DIV clocks.
- R2: A held code of 0 keeps the channel output low for the whole period.
- R3: A held code of 63 gives 63 high steps and at least one low step in every period, so no code produces a constant high.
- R4: For every code value c from 0 to 63, a channel is high for exactly c steps (c * TICK_DIV clocks) per period, with the high steps at the start of the period.
- R5: A code input is captured into the channel only when the timebase wraps from 63 to 0. A change made part-way through a period has no effect until the next period.
- R6: One clock after shdn_ni goes low, both oe outputs are 0 and both pwm outputs are 0. They stay that way, and the timebase holds at step 0, for as long as shdn_ni is low.
- R7: The held codes do not change during shutdown. The first clock after shdn_ni returns high starts a fresh period at step 0, driven by the codes held before shutdown.
- R8: While rst_ni is low, both oe and both pwm outputs are 0. After reset, both held codes start at mid-scale (32).
- R9: The two channels share the timebase but hold and compare their codes independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shdn_ni | input | 1 | Shutdown request, active low |
| code_a_i | input | 6 | Requested duty code, channel A |
| code_b_i | input | 6 | Requested duty code, channel B |
| pwm_a_o | output | 1 | PWM level, channel A |
| pwm_b_o | output | 1 | PWM level, channel B |
| oe_a_o | output | 1 | Output enable, channel A (0 = released) |
| oe_b_o | output | 1 | Output enable, channel B (0 = released) |

## Verification
The bench sweeps all 64 codes on channel A while channel B runs the mirrored code. This catches an off-by-one compare, which would show up as 64/64 duty at code 63 or as a stray step at code 0. It also catches channels that are accidentally cross-coupled. A code change is injected halfway through a period. An unsynchronised load would add high steps to the tail of that period. Shutdown is entered and left with new codes applied while it is active. A timebase that resumes instead of restarting, or a code that leaks in during shutdown, shows up as a wrong high count in the first period after release. The first period after reset is measured to confirm the mid-scale start.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int unsigned CODE_W_DEF = 6;

  function automatic int unsigned calc_tick_div(input longint unsigned clk_hz,
                                                input longint unsigned pwm_hz,
                                                input int unsigned code_w);
    longint unsigned d;
    d = clk_hz / (pwm_hz << code_w);
    return (d < 1) ? 1 : int'(d);
  endfunction
endpackage

// File: rtl/dpwm_tick_gen.sv
module dpwm_tick_gen #(
  parameter int unsigned TICK_DIV = 312
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  if (TICK_DIV == 1) begin : g_every
    assign tick_o = run_i;
  end else begin : g_div
    logic [CW-1:0] cnt_q;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (!run_i)        cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = run_i && (cnt_q == LAST);

    AST_DIV_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LAST); // R1
  end
endmodule

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  output logic [CODE_W-1:0] tb_o,
  output logic              wrap_o
);
  localparam logic [CODE_W-1:0] TB_MAX = '1;
  logic [CODE_W-1:0] tb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tb_q <= '0;
    else if (!run_i) tb_q <= '0;
    else if (tick_i) tb_q <= tb_q + 1'b1;
  end

  assign tb_o   = tb_q;
  assign wrap_o = tick_i && (tb_q == TB_MAX);

  AST_TB_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tb_q != $past(tb_q)) |-> ((tb_q == CODE_W'($past(tb_q) + 1'b1)) || (tb_q == '0))); // R1
  AST_TB_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (tb_q == '0)); // R6
endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel #(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] tb_i,
  output logic              pwm_o
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [CODE_W-1:0] TB_MAX = '1;
  logic [CODE_W-1:0] act_q;

  // code only enters at the wrap, so a running period is never altered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     act_q <= MID;
    else if (load_i) act_q <= code_i;
  end

  assign pwm_o = run_i && (tb_i < act_q);

  AST_ZERO_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q == '0) |-> !pwm_o); // R2
  AST_LAST_STEP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tb_i == TB_MAX) |-> !pwm_o); // R3
  AST_LOAD_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != $past(act_q)) |-> (tb_i == '0)); // R5
  AST_HOLD_IN_SHDN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(act_q)); // R7
endmodule

// File: rtl/dual_pwm_gen.sv
module dual_pwm_gen
  import dpwm_pkg::*;
#(
  parameter longint unsigned CLK_HZ = 100_000_000,
  parameter longint unsigned PWM_HZ = 5_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       shdn_ni,
  input  logic [5:0] code_a_i,
  input  logic [5:0] code_b_i,
  output logic       pwm_a_o,
  output logic       pwm_b_o,
  output logic       oe_a_o,
  output logic       oe_b_o
);
  localparam int unsigned CODE_W   = CODE_W_DEF;
  localparam int unsigned TICK_DIV = calc_tick_div(CLK_HZ, PWM_HZ, CODE_W);
  localparam int unsigned NCH      = 2;

  logic              run_q;
  logic              tick;
  logic              wrap;
  logic [CODE_W-1:0] tb;
  logic [CODE_W-1:0] code_arr [NCH];
  logic              pwm_arr  [NCH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= shdn_ni;
  end

  dpwm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_q),
    .tick_o(tick)
  );

  dpwm_timebase #(.CODE_W(CODE_W)) u_tb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run_q),
    .tick_i(tick),
    .tb_o  (tb),
    .wrap_o(wrap)
  );

  assign code_arr[0] = code_a_i;
  assign code_arr[1] = code_b_i;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dpwm_channel #(.CODE_W(CODE_W)) u_ch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (run_q),
      .load_i(wrap),
      .code_i(code_arr[i]),
      .tb_i  (tb),
      .pwm_o (pwm_arr[i])
    );
  end

  assign pwm_a_o = pwm_arr[0];
  assign pwm_b_o = pwm_arr[1];
  assign oe_a_o  = run_q;
  assign oe_b_o  = run_q;

  AST_SHDN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shdn_ni |=> (!oe_a_o && !oe_b_o && !pwm_a_o && !pwm_b_o)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!oe_a_o && !pwm_a_o && !pwm_b_o)); // R8
endmodule

// File: tb/sim_dual_pwm_gen.sv
module sim_dual_pwm_gen;
  localparam longint unsigned CLK_HZ = 100_000_000;
  localparam longint unsigned PWM_HZ = 390_625;
  localparam int DIV = 4;
  localparam int PER = 64 * DIV;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic shdn_ni = 1'b1;
  logic [5:0] code_a = '0;
  logic [5:0] code_b = '0;
  logic pwm_a, pwm_b, oe_a, oe_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int ha, hb;

  always #5 clk = ~clk;

  dual_pwm_gen #(.CLK_HZ(CLK_HZ), .PWM_HZ(PWM_HZ)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .shdn_ni(shdn_ni),
    .code_a_i(code_a), .code_b_i(code_b),
    .pwm_a_o(pwm_a), .pwm_b_o(pwm_b), .oe_a_o(oe_a), .oe_b_o(oe_b)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(input int n, output int a, output int b);
    a = 0; b = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      a += int'(pwm_a);
      b += int'(pwm_b);
    end
  endtask

  task automatic wait_rise_a();
    logic prev;
    prev = 1'b1;
    for (int i = 0; i < 4 * PER; i++) begin
      @(negedge clk);
      if (!prev && pwm_a) break;
      prev = pwm_a;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 outputs quiet in reset
    check("R8 oe in reset", int'(oe_a) + int'(oe_b), 0);
    check("R8 pwm in reset", int'(pwm_a) + int'(pwm_b), 0);
    rst_ni = 1'b1;
    measure(PER, ha, hb);
    check("R8 midscale A", ha, 32 * DIV);
    check("R8 midscale B", hb, 32 * DIV);
    // codes were 0 at the first wrap
    measure(PER, ha, hb);
    check("R2 code 0 A", ha, 0);
    check("R2 code 0 B", hb, 0);

    // R1 period and step length
    code_a = 6'd1;
    repeat (2 * PER) @(negedge clk);
    wait_rise_a();
    begin
      int hi_len, gap;
      hi_len = 1; gap = 1;
      while (pwm_a && hi_len < PER) begin @(negedge clk); if (pwm_a) hi_len++; gap++; end
      while (!pwm_a && gap < 2 * PER) begin @(negedge clk); gap++; end
      check("R1 step length", hi_len, DIV);
      check("R1 period", gap - 1, PER);
    end

    // R4 R9 exhaustive sweep, B mirrored
    for (int c = 0; c < 64; c++) begin
      code_a = 6'(c);
      code_b = 6'(63 - c);
      repeat (2 * PER) @(negedge clk);
      measure(PER, ha, hb);
      check("R4 sweep A", ha, c * DIV);
      check("R9 sweep B", hb, (63 - c) * DIV);
      if (c == 63) check("R3 full code A", ha, 63 * DIV);
    end

    // R5 mid-period change is deferred
    code_a = 6'd10;
    repeat (2 * PER) @(negedge clk);
    wait_rise_a();
    measure(32 * DIV - 1, ha, hb);
    code_a = 6'd50;
    measure(32 * DIV, ha, hb);
    check("R5 tail of period", ha, 0);
    measure(PER, ha, hb);
    check("R5 next period", ha, 50 * DIV);

    // R6 R7 shutdown
    code_a = 6'd40; code_b = 6'd20;
    repeat (2 * PER) @(negedge clk);
    shdn_ni = 1'b0;
    @(negedge clk);
    check("R6 oe released", int'(oe_a) + int'(oe_b), 0);
    code_a = 6'd5; code_b = 6'd7;
    measure(3 * PER, ha, hb);
    check("R6 pwm A quiet", ha, 0);
    check("R6 pwm B quiet", hb, 0);
    check("R6 oe still released", int'(oe_a) + int'(oe_b), 0);
    shdn_ni = 1'b1;
    measure(PER, ha, hb);
    check("R7 held code A", ha, 40 * DIV);
    check("R7 held code B", hb, 20 * DIV);
    measure(PER, ha, hb);
    check("R7 new code A", ha, 5 * DIV);
    check("R7 new code B", hb, 7 * DIV);

    done = 1;
    summary();
  end
endmodule